// File: doc/BRIEF.md
# Host Reset Supervisor with Watchdog

This block drives the active-low reset of a host processor. It holds reset for three causes: power-up, a low supply, and a watchdog that the host did not service in time. Time is counted in pulses of a timebase tick rather than in clock cycles. One hold period of `HOLD_TICKS` ticks stands for 250 ms. The watchdog timeouts are one, three or seven hold periods, which give 0.25 s, 0.75 s and 1.75 s. The watchdog can also be turned off.

The supply comparator sits outside the block and its result arrives on `supply_ok`. The block registers a 3-bit threshold choice and passes it to that comparator, limited to the five levels that exist. Reset is modelled as an open-drain pull: `host_rst_pull` high means the pin is being driven low. `bus_enable` lets the serial host interface run only while reset is released. Every port here is a plain control or status pin. None carries a data stream, so there is no valid/ready handshake and no back-pressure to define.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low, `host_rst_pull` is 1 and `bus_enable` is 0.
- R2: Once `supply_ok` is high after reset, `host_rst_pull` falls after one clock edge plus `HOLD_TICKS` edges on which `tick` is high.
- R3: The hold period counts only clock edges that have `tick` high. If `tick` stays low, reset stays asserted.
- R4: A low `supply_ok` sampled at any clock edge asserts `host_rst_pull` from that edge on. Reset stays asserted for as long as `supply_ok` stays low.
- R5: When the supply recovers, a full new hold period runs before reset is released. Reset is released only at an edge where `supply_ok` was high.
- R6: `wd_sel` sets the watchdog timeout: 2'b00 is `HOLD_TICKS` ticks, 2'b01 is 3×`HOLD_TICKS`, 2'b10 is 7×`HOLD_TICKS`, and 2'b11 turns the watchdog off. The watchdog can expire only while reset is released.
- R7: A `wd_kick` pulse sets the watchdog count back to zero. If the kick arrives on the same edge as the last tick of the timeout, the kick wins and no expiry occurs.
- R8: Any change of `wd_sel` restarts the watchdog count from zero on the edge where the change is seen.
- R9: While `on_battery` is high, the watchdog does not count and cannot expire. When `on_battery` goes low again, counting starts from zero.
- R10: An expiry asserts reset for exactly `HOLD_TICKS` ticks. After release, the watchdog counts again from zero.
- R11: `bus_enable` is the complement of `host_rst_pull`.
- R12: `thr_level` takes the value of `thr_cfg` one edge later. Values 5 to 7 are limited to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse; one hold period is `HOLD_TICKS` of these |
| supply_ok | input | 1 | Supply is above the selected threshold |
| on_battery | input | 1 | Device is running from backup power |
| wd_kick | input | 1 | Watchdog service strobe |
| wd_sel | input | 2 | Watchdog timeout select |
| thr_cfg | input | 3 | Requested supply threshold level |
| thr_level | output | 3 | Threshold level passed to the comparator |
| host_rst_pull | output | 1 | 1 = open-drain reset pin driven low |
| bus_enable | output | 1 | Serial host interface allowed to run |

## Verification
The bench builds the block with `HOLD_TICKS` = 4. At that value a hold period is four tick edges and the longest timeout is 28 tick edges, so every timeout setting can be run to expiry. Each release edge and each trip edge can also be checked one cycle at a time. Ticking on every cycle makes the edge counts exact. Holding `tick` low shows that the hold period stalls without ticks.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_LOW  = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } sup_state_e;

  localparam logic [1:0] WD_SHORT = 2'b00;
  localparam logic [1:0] WD_MID   = 2'b01;
  localparam logic [1:0] WD_LONG  = 2'b10;
  localparam logic [1:0] WD_OFF   = 2'b11;

  localparam int WD_MID_MULT  = 3;
  localparam int WD_LONG_MULT = 7;
endpackage

// File: rtl/sup_thr_reg.sv
module sup_thr_reg #(
  parameter int LEVELS = 5,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cfg,
  output logic [W-1:0] level
);
  localparam logic [W-1:0] TOP = W'(LEVELS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= (cfg > TOP) ? TOP : cfg;
  end

  assert_level_in_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    level <= TOP);
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
#(
  parameter int UNIT_TICKS = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run_i,
  input  logic       on_battery,
  input  logic       kick,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int MAXT = WD_LONG_MULT * UNIT_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit_m1;
  logic [1:0]    sel_q;
  logic          active, restart, last;

  always_comb begin
    case (sel)
      WD_SHORT: limit_m1 = CW'(UNIT_TICKS - 1);
      WD_MID:   limit_m1 = CW'(WD_MID_MULT * UNIT_TICKS - 1);
      WD_LONG:  limit_m1 = CW'(MAXT - 1);
      default:  limit_m1 = '0;
    endcase
  end

  assign active  = run_i && !on_battery && (sel != WD_OFF);
  assign restart = kick || (sel != sel_q);
  assign last    = (cnt == limit_m1);
  assign expire  = active && tick && !restart && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= WD_OFF;
      cnt   <= '0;
    end else begin
      sel_q <= sel;
      if (!active || restart) cnt <= '0;
      else if (tick)          cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  assert_expire_only_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> run_i);
  assert_kick_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0));
  assert_battery_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    on_battery |=> (cnt == '0));
  assert_battery_no_expire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    on_battery |-> !expire);
endmodule

// File: rtl/sup_hold_fsm.sv
module sup_hold_fsm
  import sup_pkg::*;
#(
  parameter int HOLD_TICKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic wd_expire,
  output logic run_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  sup_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LOW;
      cnt   <= '0;
    end else if (!supply_ok) begin
      state <= ST_LOW;
      cnt   <= '0;
    end else begin
      case (state)
        ST_LOW: begin
          state <= ST_HOLD;
          cnt   <= '0;
        end
        ST_HOLD: begin
          if (tick) begin
            if (cnt == LAST) begin
              state <= ST_RUN;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (wd_expire) begin
            state <= ST_HOLD;
            cnt   <= '0;
          end
        end
        default: begin
          state <= ST_LOW;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign run_o = (state == ST_RUN);

  assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> $past(tick));
  assert_trip_enters_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && supply_ok && wd_expire) |=> (state == ST_HOLD && cnt == '0));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import sup_pkg::*;
#(
  parameter int HOLD_TICKS = 250,
  parameter int THR_LEVELS = 5,
  parameter int THR_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             supply_ok,
  input  logic             on_battery,
  input  logic             wd_kick,
  input  logic [1:0]       wd_sel,
  input  logic [THR_W-1:0] thr_cfg,
  output logic [THR_W-1:0] thr_level,
  output logic             host_rst_pull,
  output logic             bus_enable
);
  logic run, wd_expire;

  sup_hold_fsm #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .wd_expire(wd_expire), .run_o(run)
  );

  sup_watchdog #(.UNIT_TICKS(HOLD_TICKS)) u_wd (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_i(run),
    .on_battery(on_battery), .kick(wd_kick), .sel(wd_sel), .expire(wd_expire)
  );

  sup_thr_reg #(.LEVELS(THR_LEVELS), .W(THR_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .cfg(thr_cfg), .level(thr_level)
  );

  assign host_rst_pull = !run;
  assign bus_enable    = run;

  assert_low_supply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> host_rst_pull);
  assert_release_needs_supply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_rst_pull) |-> $past(supply_ok));
endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
  localparam int U = 4;

  logic       clk = 0;
  logic       rst_n, tick, supply_ok, on_battery, wd_kick;
  logic [1:0] wd_sel;
  logic [2:0] thr_cfg, thr_level;
  logic       host_rst_pull, bus_enable;
  int n_checks = 0, n_fail = 0;

  always #2 clk = ~clk;

  rst_supervisor #(.HOLD_TICKS(U)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .on_battery(on_battery), .wd_kick(wd_kick), .wd_sel(wd_sel),
    .thr_cfg(thr_cfg), .thr_level(thr_level),
    .host_rst_pull(host_rst_pull), .bus_enable(bus_enable)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_rst(input string req, input int exp);
    check(req, host_rst_pull, exp);
    check({req, "/R11"}, bus_enable, !exp);
  endtask

  // n-1 edges still in reset, released at edge n
  task automatic wait_release(input string req, input int n);
    for (int i = 0; i < n - 1; i++) begin step(1); check_rst(req, 1); end
    step(1); check_rst(req, 0);
  endtask

  // n-1 edges still released, reset asserted at edge n
  task automatic expect_trip(input string req, input int n);
    for (int i = 0; i < n - 1; i++) begin step(1); check_rst(req, 0); end
    step(1); check_rst(req, 1);
  endtask

  task automatic t_boot;
    rst_n = 0; tick = 1; supply_ok = 1; on_battery = 0; wd_kick = 0;
    wd_sel = 2'b11; thr_cfg = 0;
    step(3);
    check_rst("R1", 1);
    rst_n = 1;
    wait_release("R2", 1 + U);
  endtask

  task automatic t_no_tick_R3;
    supply_ok = 0; step(1); check_rst("R4", 1);
    supply_ok = 1; tick = 0;
    for (int i = 0; i < 12; i++) begin step(1); check_rst("R3", 1); end
    tick = 1;
    wait_release("R3", U);
  endtask

  task automatic t_supply_R4_R5;
    supply_ok = 0;
    for (int i = 0; i < 6; i++) begin step(1); check_rst("R4", 1); end
    supply_ok = 1;
    wait_release("R5", 1 + U);
  endtask

  task automatic t_timeouts_R6;
    wd_sel = 2'b00; expect_trip("R6", 1 + U);
    wait_release("R10", U);
    expect_trip("R10", U);
    wait_release("R10", U);
    wd_sel = 2'b01; expect_trip("R6", 1 + 3 * U);
    wait_release("R10", U);
    wd_sel = 2'b10; expect_trip("R6", 1 + 7 * U);
    wait_release("R10", U);
    wd_sel = 2'b11;
    for (int i = 0; i < 10 * U; i++) begin step(1); check_rst("R6", 0); end
  endtask

  task automatic t_kick_R7;
    wd_sel = 2'b00; step(1); check_rst("R8", 0);
    for (int k = 0; k < 3; k++) begin
      step(U - 1); check_rst("R7", 0);
      wd_kick = 1; step(1); wd_kick = 0; check_rst("R7", 0);
    end
    expect_trip("R7", U);
    wait_release("R10", U);
  endtask

  task automatic t_sel_change_R8;
    step(U - 1); check_rst("R8", 0);
    wd_sel = 2'b01; step(1); check_rst("R8", 0);
    expect_trip("R8", 3 * U);
    wait_release("R10", U);
    wd_sel = 2'b00; step(1); check_rst("R8", 0);
  endtask

  task automatic t_battery_R9;
    on_battery = 1;
    for (int i = 0; i < 10 * U; i++) begin step(1); check_rst("R9", 0); end
    on_battery = 0;
    expect_trip("R9", U);
    wait_release("R10", U);
  endtask

  task automatic t_thr_R12;
    int cfgv[6] = '{2, 4, 5, 7, 0, 3};
    int expv[6] = '{2, 4, 4, 4, 0, 3};
    for (int i = 0; i < 6; i++) begin
      thr_cfg = 3'(cfgv[i]); step(1);
      check("R12", thr_level, expv[i]);
    end
  endtask

  initial begin
    t_boot();
    t_no_tick_R3();
    t_supply_R4_R5();
    t_timeouts_R6();
    t_kick_R7();
    t_sel_change_R8();
    t_battery_R9();
    t_thr_R12();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule